// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This combinational block sits beside the instruction decoder of a core that supports hypervisor extensions. It takes the current privilege level and virtualization state, a few trap-control bits from the status registers, and a one-hot instruction class produced by the decoder. It decides whether the instruction must raise an illegal-instruction exception, a virtual-instruction exception, or neither.

The classes are address-translation fences, cache-invalidate fence parts, hypervisor guest-physical fences, hypervisor virtual-address fences, hypervisor virtual-machine loads and stores, floating-point instructions and vector instructions. Host modes (V=0) can only produce the illegal outcome from privilege checks. Guest modes (V=1) can only produce the virtual outcome from privilege checks. A floating-point or vector unit that is switched off raises the illegal outcome in every mode. The trap unit downstream consumes the two flags directly.

Top module: `priv_insn_gate`

## Requirements
- R1: When `insn_class` is all zeros, `raise_illegal` and `raise_virtual` are both 0.
- R2: Class bit 0 (address-translation fence) raises illegal in host supervisor (mode 1, V=0) when `tvm_trap`=1 and always in host user (mode 0, V=0). It raises virtual in guest supervisor (mode 1, V=1) when `vtvm_trap`=1 and always in guest user (mode 0, V=1).
- R3: Class bit 1 (fence part) raises illegal only in host user and raises virtual only in guest user.
- R4: Class bit 2 (guest-physical hypervisor fence) raises illegal in host supervisor with `tvm_trap`=1 or in host user, and raises virtual in guest supervisor or guest user.
- R5: Class bit 3 (virtual-address hypervisor fence) raises illegal only in host user, and raises virtual in guest supervisor or guest user.
- R6: Class bit 4 (hypervisor virtual-machine load/store/execute-load) raises illegal in host user when `hu_allow`=0, and raises virtual in guest supervisor or guest user.
- R7: Class bit 5 (floating point) raises illegal in any mode when `fp_status`=0, and class bit 6 (vector) raises illegal in any mode when `vec_status`=0. The status encoding is 0 off, 1 initial, 2 clean, 3 dirty. Values 1 to 3 never raise anything for these classes.
- R8: Mode 3 (machine) and the reserved mode 2 raise neither flag for class bits 0 to 4, whatever the V, `tvm_trap`, `vtvm_trap` and `hu_allow` inputs are.
- R9: The two flags are never 1 at the same time. With several class bits set, each flag is the OR over the classes, and `raise_virtual` is forced to 0 whenever `raise_illegal` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_mode | input | 2 | Privilege level: 0 user, 1 supervisor, 2 reserved, 3 machine |
| cur_virt | input | 1 | Virtualization flag (1 = guest) |
| tvm_trap | input | 1 | Host trap-virtual-memory control |
| vtvm_trap | input | 1 | Guest trap-virtual-memory control |
| hu_allow | input | 1 | Allows hypervisor loads/stores from host user |
| fp_status | input | 2 | Floating-point unit state field |
| vec_status | input | 2 | Vector unit state field |
| insn_class | input | 7 | One-hot instruction class from the decoder |
| raise_illegal | output | 1 | Illegal-instruction outcome |
| raise_virtual | output | 1 | Virtual-instruction outcome |

## Verification
The bench sweeps every combination of mode, V, the three control bits, both status fields and each single class, including the all-zero class. It then adds random multi-bit classes. The sweep targets the cases where host and guest checks are easy to mix up. A design that ignored V would raise illegal in guest user for fence parts. A design that shared the guest-physical rule with the virtual-address fence would miss illegal in host supervisor with TVM set. A design that let machine mode skip the off-unit check would let floating-point run with FS off. The multi-bit patterns pair an off unit with a guest-mode fence, which exposes a design that raises both flags at once.

// File: rtl/privchk_pkg.sv
package privchk_pkg;
  localparam int NUM_CLASSES = 7;
  localparam int MODE_W      = 2;
  localparam int XS_W        = 2;

  localparam int CLS_XLATE_FENCE = 0;
  localparam int CLS_FENCE_PART  = 1;
  localparam int CLS_HFENCE_GPA  = 2;
  localparam int CLS_HFENCE_VA   = 3;
  localparam int CLS_HYP_LDST    = 4;
  localparam int CLS_FP          = 5;
  localparam int CLS_VEC         = 6;

  localparam logic [NUM_CLASSES-1:0] UNIT_MASK =
    (NUM_CLASSES'(1) << CLS_FP) | (NUM_CLASSES'(1) << CLS_VEC);

  typedef enum logic [MODE_W-1:0] {
    MODE_USER = 2'd0,
    MODE_SUP  = 2'd1,
    MODE_RSV  = 2'd2,
    MODE_MACH = 2'd3
  } mode_e;

  // decoded execution context; at most one bit set
  typedef struct packed {
    logic host_sup;
    logic host_usr;
    logic guest_sup;
    logic guest_usr;
  } ctx_t;

  function automatic logic state_off(input logic [XS_W-1:0] st);
    return st == '0;
  endfunction

  // host-side illegal rule for one class
  function automatic logic host_rule(input int cls, input ctx_t c, input logic tvm,
                                     input logic hu_bit, input logic fp_off,
                                     input logic vec_off);
    case (cls)
      CLS_XLATE_FENCE, CLS_HFENCE_GPA: return (c.host_sup & tvm) | c.host_usr;
      CLS_FENCE_PART, CLS_HFENCE_VA:   return c.host_usr;
      CLS_HYP_LDST:                    return c.host_usr & ~hu_bit;
      CLS_FP:                          return fp_off;
      CLS_VEC:                         return vec_off;
      default:                         return 1'b0;
    endcase
  endfunction

  // guest-side virtual rule for one class
  function automatic logic guest_rule(input int cls, input ctx_t c, input logic vtvm);
    case (cls)
      CLS_XLATE_FENCE:                             return (c.guest_sup & vtvm) | c.guest_usr;
      CLS_FENCE_PART:                              return c.guest_usr;
      CLS_HFENCE_GPA, CLS_HFENCE_VA, CLS_HYP_LDST: return c.guest_sup | c.guest_usr;
      default:                                     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/privchk_ctx_decode.sv
module privchk_ctx_decode
  import privchk_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              virt_i,
  output ctx_t              ctx_o
);
  mode_e mode;
  assign mode = mode_e'(mode_i);

  always_comb begin
    ctx_o = '0;
    case (mode)
      MODE_USER: begin
        ctx_o.host_usr  = ~virt_i;
        ctx_o.guest_usr = virt_i;
      end
      MODE_SUP: begin
        ctx_o.host_sup  = ~virt_i;
        ctx_o.guest_sup = virt_i;
      end
      default: ctx_o = '0;
    endcase
  end

  // R8: machine and reserved levels yield no context; at most one context bit
  always_comb begin
    if (!$isunknown({mode_i, virt_i})) begin
      a_r8_ctx_onehot: assert ($onehot0(ctx_o));
      a_r8_no_ctx_high_mode: assert (!mode_i[1] || ctx_o == '0);
    end
  end
endmodule

// File: rtl/privchk_host_rules.sv
module privchk_host_rules
  import privchk_pkg::*;
#(
  parameter int N_CLS = NUM_CLASSES,
  parameter int ST_W  = XS_W
) (
  input  ctx_t             ctx_i,
  input  logic             tvm_i,
  input  logic             hu_i,
  input  logic [ST_W-1:0]  fs_i,
  input  logic [ST_W-1:0]  vs_i,
  input  logic [N_CLS-1:0] cls_i,
  output logic [N_CLS-1:0] hit_o
);
  logic fp_off, vec_off;
  assign fp_off  = fs_i == '0;
  assign vec_off = vs_i == '0;

  for (genvar i = 0; i < N_CLS; i++) begin : g_cls
    assign hit_o[i] = cls_i[i] & host_rule(i, ctx_i, tvm_i, hu_i, fp_off, vec_off);
  end

  // R8: without a host context only the unit-off classes can hit
  always_comb begin
    if (!$isunknown({ctx_i, tvm_i, hu_i, fs_i, vs_i, cls_i})) begin
      if (!ctx_i.host_sup && !ctx_i.host_usr)
        a_r8_host_silent: assert ((hit_o & ~N_CLS'(UNIT_MASK)) == '0);
    end
  end
endmodule

// File: rtl/privchk_guest_rules.sv
module privchk_guest_rules
  import privchk_pkg::*;
#(
  parameter int N_CLS = NUM_CLASSES
) (
  input  ctx_t             ctx_i,
  input  logic             vtvm_i,
  input  logic [N_CLS-1:0] cls_i,
  output logic [N_CLS-1:0] hit_o
);
  for (genvar i = 0; i < N_CLS; i++) begin : g_cls
    assign hit_o[i] = cls_i[i] & guest_rule(i, ctx_i, vtvm_i);
  end

  // R9 precondition: outside a guest context nothing is virtual
  always_comb begin
    if (!$isunknown({ctx_i, vtvm_i, cls_i})) begin
      if (!ctx_i.guest_sup && !ctx_i.guest_usr)
        a_r9_guest_only: assert (hit_o == '0);
    end
  end
endmodule

// File: rtl/priv_insn_gate.sv
module priv_insn_gate
  import privchk_pkg::*;
(
  input  logic [1:0] cur_mode,
  input  logic       cur_virt,
  input  logic       tvm_trap,
  input  logic       vtvm_trap,
  input  logic       hu_allow,
  input  logic [1:0] fp_status,
  input  logic [1:0] vec_status,
  input  logic [6:0] insn_class,
  output logic       raise_illegal,
  output logic       raise_virtual
);
  ctx_t                   ctx;
  logic [NUM_CLASSES-1:0] host_hits;
  logic [NUM_CLASSES-1:0] guest_hits;
  logic                   host_any, guest_any;

  privchk_ctx_decode u_ctx (
    .mode_i (cur_mode),
    .virt_i (cur_virt),
    .ctx_o  (ctx)
  );

  privchk_host_rules #(.N_CLS(NUM_CLASSES), .ST_W(XS_W)) u_host (
    .ctx_i (ctx),
    .tvm_i (tvm_trap),
    .hu_i  (hu_allow),
    .fs_i  (fp_status),
    .vs_i  (vec_status),
    .cls_i (insn_class),
    .hit_o (host_hits)
  );

  privchk_guest_rules #(.N_CLS(NUM_CLASSES)) u_guest (
    .ctx_i  (ctx),
    .vtvm_i (vtvm_trap),
    .cls_i  (insn_class),
    .hit_o  (guest_hits)
  );

  assign host_any      = |host_hits;
  assign guest_any     = |guest_hits;
  assign raise_illegal = host_any;
  assign raise_virtual = guest_any & ~host_any;

  always_comb begin
    if (!$isunknown({cur_mode, cur_virt, tvm_trap, vtvm_trap, hu_allow,
                     fp_status, vec_status, insn_class})) begin
      a_r9_exclusive: assert (!(raise_illegal && raise_virtual));
      if (insn_class == '0)
        a_r1_idle_quiet: assert (!raise_illegal && !raise_virtual);
      if (state_off(fp_status) && insn_class[CLS_FP])
        a_r7_fp_off: assert (raise_illegal);
    end
  end
endmodule

// File: tb/priv_insn_gate_tb.sv
module priv_insn_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cur_mode = '0;
  logic       cur_virt = 1'b0;
  logic       tvm_trap = 1'b0, vtvm_trap = 1'b0, hu_allow = 1'b0;
  logic [1:0] fp_status = 2'd1, vec_status = 2'd1;
  logic [6:0] insn_class = '0;
  logic       raise_illegal, raise_virtual;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  priv_insn_gate u_dut (.*);

  // reference: returns {illegal, virtual}
  function automatic logic [1:0] model(input logic [1:0] m, input logic v, input logic t,
                                       input logic vt, input logic h, input logic [1:0] f,
                                       input logic [1:0] s, input logic [6:0] c);
    logic ill = 0, vir = 0;
    bit hs = (m == 2'd1) && !v;
    bit hu = (m == 2'd0) && !v;
    bit gs = (m == 2'd1) && v;
    bit gu = (m == 2'd0) && v;
    if (c[5] && f == 2'd0) ill = 1;
    if (c[6] && s == 2'd0) ill = 1;
    if (c[0]) begin
      if (hu || (hs && t)) ill = 1;
      if (gu || (gs && vt)) vir = 1;
    end
    if (c[1]) begin
      if (hu) ill = 1;
      if (gu) vir = 1;
    end
    if (c[2]) begin
      if (hu || (hs && t)) ill = 1;
      if (gs || gu) vir = 1;
    end
    if (c[3]) begin
      if (hu) ill = 1;
      if (gs || gu) vir = 1;
    end
    if (c[4]) begin
      if (hu && !h) ill = 1;
      if (gs || gu) vir = 1;
    end
    if (ill) vir = 0;
    return {ill, vir};
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [6:0] c);
    if (c == '0) return "R1";
    if ($countones(c) > 1) return "R9";
    if (m[1] && c[4:0] != '0) return "R8";
    if (c[0]) return "R2";
    if (c[1]) return "R3";
    if (c[2]) return "R4";
    if (c[3]) return "R5";
    if (c[4]) return "R6";
    return "R7";
  endfunction

  task automatic run(input logic [1:0] m, input logic v, input logic t, input logic vt,
                     input logic h, input logic [1:0] f, input logic [1:0] s,
                     input logic [6:0] c);
    logic [1:0] exp;
    @(posedge clk);
    #1;
    cur_mode = m; cur_virt = v; tvm_trap = t; vtvm_trap = vt; hu_allow = h;
    fp_status = f; vec_status = s; insn_class = c;
    @(negedge clk);
    exp = model(m, v, t, vt, h, f, s, c);
    checks++;
    if ({raise_illegal, raise_virtual} !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d v=%0b tvm=%0b vtvm=%0b hu=%0b fs=%0d vs=%0d cls=%b actual=%b expected=%b",
               tag_of(m, c), m, v, t, vt, h, f, s, c, {raise_illegal, raise_virtual}, exp);
    end
    checks++;
    if (raise_illegal && raise_virtual) begin
      errors++;
      $display("FAIL R9 both flags high actual=11 expected=not 11");
    end
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: quiet at start with no class
    @(negedge clk);
    checks++;
    if (raise_illegal !== 1'b0 || raise_virtual !== 1'b0) begin
      errors++;
      $display("FAIL R1 initial actual=%b%b expected=00", raise_illegal, raise_virtual);
    end
    // directed corners: R2 host sup with tvm, R3 guest user part, R6 hu gating, R7 machine fp off
    run(2'd1, 0, 1, 0, 0, 2'd1, 2'd1, 7'b0000001);
    run(2'd0, 1, 0, 0, 0, 2'd1, 2'd1, 7'b0000010);
    run(2'd0, 0, 0, 0, 1, 2'd1, 2'd1, 7'b0010000);
    run(2'd3, 0, 0, 0, 0, 2'd0, 2'd1, 7'b0100000);
    run(2'd1, 1, 0, 0, 0, 2'd1, 2'd0, 7'b1001000);
    // exhaustive sweep, all R1..R8 cases
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 2; v++)
        for (int k = 0; k < 8; k++)
          for (int f = 0; f < 4; f++)
            for (int s = 0; s < 4; s++)
              for (int c = 0; c < 8; c++)
                run(2'(m), 1'(v), k[2], k[1], k[0], 2'(f), 2'(s),
                    (c == 0) ? 7'd0 : 7'(1 << (c - 1)));
    // R9: random multi-class patterns
    for (int n = 0; n < 600; n++) begin
      logic [6:0] c;
      c = 7'($urandom);
      if ($countones(c) < 2) c = c | 7'b0100001;
      run(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          2'($urandom), 2'($urandom), c);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule